// File: doc/BRIEF.md
# HDLC Data-Link Byte Receiver

This block turns a serial data-link bit stream into bytes for a host. An upstream frame monitor supplies one bit per cycle of its bit-enable strobe; the receiver finds the flag sequences that delimit frames, strips the zeros inserted for transparency, assembles bytes least significant bit first and checks the 16-bit frame check sequence. Bytes go into a byte FIFO that the host pops one entry at a time.

Each frame that carries data ends with a status byte in the same FIFO, so the host can split frames and judge each one. In normal mode the two FCS bytes are dropped and only payload bytes are stored. In report-capture mode every received byte is kept, including the three header bytes, the four two-byte one-second report words and both FCS bytes. A loss-of-alignment input from the frame monitor stops the current frame and makes the receiver look for a new flag.

Top module: `dlink_hdlc_rx`

## Requirements
- R1: After reset the FIFO is empty: `fifo_empty`=1, `fifo_full`=0, `fifo_count`=0.
- R2: `bit_in` is sampled only in cycles with `bit_en`=1. In every other cycle it has no effect on the FIFO.
- R3: While `rx_en`=0 nothing is written to the FIFO. The receiver stays in flag search until a flag arrives with `rx_en`=1.
- R4: The flag is the bit pattern 0x7E (0,1,1,1,1,1,1,0 in time order). Data lies between an opening flag and a closing flag. Flags with no data between them write nothing. Before the first flag, data bits are ignored.
- R5: A 0 that follows five consecutive 1s inside a frame is removed before bytes are assembled. Bytes are assembled with the first received bit as bit 0.
- R6: The FCS is CRC-16 with polynomial x^16+x^12+x^5+1. It is computed LSB-first and preset to 0xFFFF. The transmitter sends the complement of the CRC, low byte first. A frame is good when the CRC over data and FCS equals 0xF0B8. Otherwise status bit 0 is set.
- R7: With `prm_mode`=0, a closed frame stores its payload bytes in order, without the last two (FCS) bytes, and then one status byte. The status byte is 0x00 for a good frame.
- R8: With `prm_mode`=1, every received byte is stored, including both FCS bytes, and then the status byte. A 3-byte header plus four 2-byte report words gives 14 FIFO entries.
- R9: Seven consecutive 1s abort the frame. If data had been received, a status byte with bit 1 set is written, and any held FCS-candidate bytes are discarded. The receiver then searches for a flag.
- R10: If the bit count between the flags is not a multiple of eight, status bit 2 is set.
- R11: Asserting `lof` ends a frame in progress the same way an abort does (status bit 1). The next frame needs a new opening flag.
- R12: The FIFO holds 64 bytes. A write while it is full is dropped and sets a sticky overflow flag. That flag appears as bit 3 of the next status byte that is stored, and is cleared when that status byte is stored.
- R13: `rd_data` shows the oldest entry. `rd_en`=1 removes it. `rd_en` while the FIFO is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receiver enable |
| prm_mode | input | 1 | Report-capture mode: keep FCS bytes in the FIFO |
| lof | input | 1 | Loss of frame alignment from the upstream monitor |
| bit_en | input | 1 | Data-link bit strobe |
| bit_in | input | 1 | Data-link bit |
| rd_en | input | 1 | Host pop request |
| rd_data | output | 8 | Oldest FIFO entry |
| fifo_empty | output | 1 | FIFO holds no entry |
| fifo_full | output | 1 | FIFO holds 64 entries |
| fifo_count | output | 7 | Number of stored entries |

## Verification
A wrong internal state has a short path to the ports:
- A miscounted run of 1s or a bad destuffing decision shifts every later bit of the frame. The stored bytes are then wrong from the first affected byte onward, and the status byte at the closing flag flags an FCS error.
- A stale delay line or a stale hold stage shows as extra or missing bytes, visible through `fifo_count` one cycle after the closing flag.
- A stale sticky overflow shows up in bit 3 of the next status byte.

The bench therefore compares the count and every popped byte against a queue model, frame by frame.

// File: rtl/dlrx_pkg.sv
package dlrx_pkg;
   localparam int          BYTE_W     = 8;
   localparam int          CRC_W      = 16;
   localparam int          FCS_BYTES  = CRC_W / BYTE_W;
   localparam logic [15:0] CRC_POLY_R = 16'h8408;
   localparam logic [15:0] CRC_PRESET = 16'hFFFF;
   localparam logic [15:0] CRC_GOOD   = 16'hF0B8;

   typedef struct packed {
      logic [3:0] spare;
      logic       ovf;
      logic       nonint;
      logic       abrt;
      logic       fcs_err;
   } rx_stat_t;
endpackage

// File: rtl/dlrx_flagdet.sv
module dlrx_flagdet #(
   parameter int LAG = 7
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic bit_en,
   input  logic bit_in,
   output logic ev_flag,
   output logic ev_abort,
   output logic dat_vld,
   output logic dat
);
   localparam int LW = $clog2(LAG + 1);
   localparam logic [LW-1:0] LFULL = LW'(LAG);

   if (LAG != 7) begin : g_bad_lag
      $error("flag detector lag must equal flag length minus one");
   end

   logic [2:0]     ones_q;
   logic [LAG-1:0] line_q;
   logic [LW-1:0]  fill_q;
   logic           stuff, push;

   always_comb begin
      ev_flag  = !clr && bit_en && !bit_in && (ones_q == 3'd6);
      ev_abort = !clr && bit_en &&  bit_in && (ones_q == 3'd6);
      stuff    = bit_en && !bit_in && (ones_q == 3'd5);
      push     = !clr && bit_en && !ev_flag && !stuff && !(bit_in && ones_q >= 3'd6);
      dat_vld  = push && (fill_q == LFULL);
      dat      = line_q[0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ones_q <= '0;
         line_q <= '0;
         fill_q <= '0;
      end else if (clr) begin
         ones_q <= '0;
         fill_q <= '0;
      end else if (bit_en) begin
         ones_q <= bit_in ? ((ones_q == 3'd7) ? 3'd7 : ones_q + 3'd1) : 3'd0;
         if (ev_flag || ev_abort) begin
            fill_q <= '0;
         end else if (push) begin
            line_q <= {bit_in, line_q[LAG-1:1]};
            if (fill_q != LFULL) fill_q <= fill_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/dlrx_crc.sv
module dlrx_crc #(
   parameter int               W      = 16,
   parameter logic [W-1:0]     POLY   = 16'h8408,
   parameter logic [W-1:0]     PRESET = 16'hFFFF
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         init,
   input  logic         vld,
   input  logic         din,
   output logic [W-1:0] crc
);
   logic [W-1:0] nxt;
   logic         fb;

   assign fb = crc[0] ^ din;

   for (genvar i = 0; i < W; i++) begin : g_bit
      if (i == W - 1) begin : g_top
         assign nxt[i] = fb & POLY[i];
      end else begin : g_low
         assign nxt[i] = crc[i+1] ^ (fb & POLY[i]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    crc <= PRESET;
      else if (init) crc <= PRESET;
      else if (vld)  crc <= nxt;
   end
endmodule

// File: rtl/dlrx_fifo.sv
module dlrx_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 64
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic [W-1:0]           wr_data,
   input  logic                   rd_en,
   output logic [W-1:0]           rd_data,
   output logic                   empty,
   output logic                   full,
   output logic [$clog2(DEPTH):0] count
);
   localparam int AW = $clog2(DEPTH);

   if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("FIFO depth must be a power of two of at least 4");
   end

   logic [W-1:0] mem [DEPTH];
   logic [AW:0]  wp, rp;
   logic         wr_ok, rd_ok;

   assign empty   = (wp == rp);
   assign full    = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
   assign wr_ok   = wr_en && !full;
   assign rd_ok   = rd_en && !empty;
   assign rd_data = mem[rp[AW-1:0]];

   always_ff @(posedge clk) begin
      if (wr_ok) mem[wp[AW-1:0]] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
      end else begin
         if (wr_ok) wp <= wp + 1'b1;
         if (rd_ok) rp <= rp + 1'b1;
         count <= count + (AW+1)'(wr_ok) - (AW+1)'(rd_ok);
      end
   end
endmodule

// File: rtl/dlink_hdlc_rx.sv
module dlink_hdlc_rx
   import dlrx_pkg::*;
#(
   parameter int FIFO_DEPTH = 64
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        rx_en,
   input  logic                        prm_mode,
   input  logic                        lof,
   input  logic                        bit_en,
   input  logic                        bit_in,
   input  logic                        rd_en,
   output logic [BYTE_W-1:0]           rd_data,
   output logic                        fifo_empty,
   output logic                        fifo_full,
   output logic [$clog2(FIFO_DEPTH):0] fifo_count
);
   localparam int BCW = $clog2(BYTE_W);
   localparam int HCW = $clog2(FCS_BYTES + 1);
   localparam logic [BCW-1:0] LAST_BIT = BCW'(BYTE_W - 1);
   localparam logic [HCW-1:0] HOLD_MAX = HCW'(FCS_BYTES);

   logic              clr, ev_flag, ev_abort, dat_vld, dat;
   logic [CRC_W-1:0]  crc;
   logic              in_frame_q, has_data_q, ovf_q;
   logic [BCW-1:0]    bcnt_q;
   logic [BYTE_W-1:0] shreg_q, byte_val;
   logic [BYTE_W-1:0] hold_q [FCS_BYTES];
   logic [HCW-1:0]    hcnt_q;
   logic              fin_ok, fin_abt, byte_done, wr_en;
   logic [BYTE_W-1:0] wr_data;
   rx_stat_t          stat;

   assign clr = !rx_en || lof;

   dlrx_flagdet #(.LAG(7)) u_det (
      .clk(clk), .rst_n(rst_n), .clr(clr), .bit_en(bit_en), .bit_in(bit_in),
      .ev_flag(ev_flag), .ev_abort(ev_abort), .dat_vld(dat_vld), .dat(dat)
   );

   dlrx_crc #(.W(CRC_W), .POLY(CRC_POLY_R), .PRESET(CRC_PRESET)) u_crc (
      .clk(clk), .rst_n(rst_n), .init(clr || ev_flag || ev_abort),
      .vld(dat_vld && in_frame_q), .din(dat), .crc(crc)
   );

   always_comb begin
      fin_ok    = !clr && ev_flag && in_frame_q && has_data_q;
      fin_abt   = rx_en && in_frame_q && has_data_q && (lof || ev_abort);
      byte_done = !clr && in_frame_q && dat_vld && (bcnt_q == LAST_BIT);
      byte_val  = {dat, shreg_q[BYTE_W-1:1]};
      stat         = '0;
      stat.fcs_err = fin_ok && (crc != CRC_GOOD);
      stat.nonint  = fin_ok && (bcnt_q != '0);
      stat.abrt    = fin_abt;
      stat.ovf     = ovf_q;
      wr_en   = 1'b0;
      wr_data = '0;
      if (fin_ok || fin_abt) begin
         wr_en   = 1'b1;
         wr_data = stat;
      end else if (byte_done) begin
         if (prm_mode) begin
            wr_en   = 1'b1;
            wr_data = byte_val;
         end else if (hcnt_q == HOLD_MAX) begin
            wr_en   = 1'b1;
            wr_data = hold_q[FCS_BYTES-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_frame_q <= 1'b0;
         has_data_q <= 1'b0;
         bcnt_q     <= '0;
         shreg_q    <= '0;
         hcnt_q     <= '0;
         ovf_q      <= 1'b0;
         for (int i = 0; i < FCS_BYTES; i++) hold_q[i] <= '0;
      end else begin
         if (wr_en && fifo_full)      ovf_q <= 1'b1;
         else if (fin_ok || fin_abt)  ovf_q <= 1'b0;

         if (clr || ev_abort) begin
            in_frame_q <= 1'b0;
            has_data_q <= 1'b0;
            bcnt_q     <= '0;
            hcnt_q     <= '0;
         end else if (ev_flag) begin
            in_frame_q <= 1'b1;
            has_data_q <= 1'b0;
            bcnt_q     <= '0;
            hcnt_q     <= '0;
         end else if (dat_vld && in_frame_q) begin
            has_data_q <= 1'b1;
            shreg_q    <= byte_val;
            bcnt_q     <= bcnt_q + 1'b1;
            if (byte_done && !prm_mode) begin
               hold_q[0] <= byte_val;
               for (int i = 1; i < FCS_BYTES; i++) hold_q[i] <= hold_q[i-1];
               if (hcnt_q != HOLD_MAX) hcnt_q <= hcnt_q + 1'b1;
            end
         end
      end
   end

   dlrx_fifo #(.W(BYTE_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_en(rd_en), .rd_data(rd_data), .empty(fifo_empty),
      .full(fifo_full), .count(fifo_count)
   );
endmodule

// File: rtl/dlrx_chk.sv
module dlrx_chk #(
   parameter int DEPTH = 64
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   rx_en,
   input logic                   lof,
   input logic                   bit_en,
   input logic                   rd_en,
   input logic                   fifo_empty,
   input logic                   fifo_full,
   input logic [$clog2(DEPTH):0] fifo_count
);
   localparam int CW = $clog2(DEPTH) + 1;

   // R1, R13: the empty flag follows the entry count
   a_r1_empty_matches_count: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_empty == (fifo_count == '0));

   // R12: the full flag follows the entry count
   a_r12_full_matches_count: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_full == (fifo_count == CW'(DEPTH)));

   // R12: a full FIFO stays full until the host reads
   a_r12_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_full && !rd_en |=> fifo_full);

   // R3: a disabled receiver never adds entries
   a_r3_disabled_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_en |=> fifo_count <= $past(fifo_count));

   // R2: no strobe, no alignment loss, no read: nothing changes
   a_r2_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_en && !lof && !rd_en |=> $stable(fifo_count));

   // R13: a read of a non-empty FIFO with no write removes one entry
   a_r13_pop_decrements: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en && !fifo_empty && !bit_en && !lof |=> fifo_count == CW'($past(fifo_count) - 1'b1));
endmodule

bind dlink_hdlc_rx dlrx_chk #(.DEPTH(FIFO_DEPTH)) u_chk (.*);

// File: tb/test_dlink_hdlc_rx.sv
module test_dlink_hdlc_rx;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_en = 1'b1, prm_mode = 1'b0, lof = 1'b0;
   logic       bit_en = 1'b0, bit_in = 1'b0, rd_en = 1'b0;
   logic [7:0] rd_data;
   logic       fifo_empty, fifo_full;
   logic [6:0] fifo_count;

   int         n_cmp = 0, n_bad = 0;
   bit         done = 1'b0;
   bit         gap = 1'b0;
   int         tx_ones = 0;
   logic [15:0] tx_crc = 16'hFFFF;
   logic [7:0] fr [0:15];
   logic [7:0] q [$];
   bit         m_ovf = 1'b0;

   always #5 clk = ~clk;

   dlink_hdlc_rx i_dlink_hdlc_rx (
      .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .prm_mode(prm_mode), .lof(lof),
      .bit_en(bit_en), .bit_in(bit_in), .rd_en(rd_en), .rd_data(rd_data),
      .fifo_empty(fifo_empty), .fifo_full(fifo_full), .fifo_count(fifo_count)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   // model of the FIFO with full-drop and sticky overflow
   task automatic push_exp(input logic [7:0] b);
      if (q.size() < 64) q.push_back(b); else m_ovf = 1'b1;
   endtask

   task automatic push_status(input logic [7:0] base);
      logic [7:0] s = base | (m_ovf ? 8'h08 : 8'h00);
      if (q.size() < 64) begin q.push_back(s); m_ovf = 1'b0; end
      else m_ovf = 1'b1;
   endtask

   task automatic send_bit(input logic b);
      bit_in = b; bit_en = 1'b1;
      @(negedge clk);
      bit_en = 1'b0;
      if (gap) begin bit_in = ~b; @(negedge clk); end
   endtask

   task automatic send_flag();
      send_bit(0); for (int i = 0; i < 6; i++) send_bit(1); send_bit(0);
      tx_ones = 0;
   endtask

   task automatic send_dbit(input logic b);
      logic fb = tx_crc[0] ^ b;
      tx_crc = {1'b0, tx_crc[15:1]} ^ (fb ? 16'h8408 : 16'h0000);
      send_bit(b);
      tx_ones = b ? tx_ones + 1 : 0;
      if (tx_ones == 5) begin send_bit(0); tx_ones = 0; end
   endtask

   task automatic send_dbyte(input logic [7:0] v);
      for (int i = 0; i < 8; i++) send_dbit(v[i]);
   endtask

   // sends fr[0..n-1] plus FCS and closing flag; updates the model
   task automatic send_frame(input int n, input bit bad, input bit keep_fcs, input bit model);
      logic [15:0] fcs;
      send_flag();
      tx_crc = 16'hFFFF;
      for (int i = 0; i < n; i++) send_dbyte(fr[i]);
      fcs = ~tx_crc ^ (bad ? 16'h0001 : 16'h0000);
      send_dbyte(fcs[7:0]);
      send_dbyte(fcs[15:8]);
      send_flag();
      if (model) begin
         for (int i = 0; i < n; i++) push_exp(fr[i]);
         if (keep_fcs) begin push_exp(fcs[7:0]); push_exp(fcs[15:8]); end
         push_status((tx_crc != 16'hF0B8) ? 8'h01 : 8'h00);
      end
   endtask

   task automatic drain(input string tag);
      chk(int'(fifo_count) == q.size(), {tag, " count"}, fifo_count, q.size());
      while (q.size() > 0) begin
         logic [7:0] e = q.pop_front();
         chk(!fifo_empty && rd_data == e, tag, rd_data, e);
         rd_en = 1'b1;
         @(negedge clk);
         rd_en = 1'b0;
      end
      chk(fifo_empty && fifo_count == 0, {tag, " empty after drain"}, fifo_count, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(fifo_empty && !fifo_full && fifo_count == 0, "R1 reset", fifo_count, 0);

      // R4: data before any flag is ignored, empty flag pairs write nothing
      for (int i = 0; i < 20; i++) send_bit(i % 3 == 0);
      send_flag(); send_flag(); send_flag();
      chk(fifo_count == 0, "R4 no data between flags", fifo_count, 0);

      // R2, R5, R6, R7: stuffing-heavy frame with garbage between strobes
      gap = 1'b1;
      fr[0] = 8'h01; fr[1] = 8'h7E; fr[2] = 8'hFF; fr[3] = 8'h3C; fr[4] = 8'hF8;
      send_frame(5, 1'b0, 1'b0, 1'b1);
      repeat (3) @(negedge clk);
      drain("R2/R5/R7 stuffed frame");
      gap = 1'b0;

      // R6: corrupted FCS gives status bit 0
      fr[0] = 8'h5A; fr[1] = 8'hC3;
      send_frame(2, 1'b1, 1'b0, 1'b1);
      drain("R6 bad FCS");

      // R8: report capture, 3 header bytes + 8 report bytes
      prm_mode = 1'b1;
      for (int i = 0; i < 11; i++) fr[i] = 8'(i * 37 + 3);
      send_frame(11, 1'b0, 1'b1, 1'b1);
      chk(fifo_count == 14, "R8 entry count", fifo_count, 14);
      drain("R8 report frame");
      prm_mode = 1'b0;

      // R9: abort after three bytes, then data without a flag is ignored
      send_flag(); send_dbyte(8'h11); send_dbyte(8'h22); send_dbyte(8'h33);
      for (int i = 0; i < 8; i++) send_bit(1);
      push_status(8'h02);
      send_dbyte(8'h55); send_dbyte(8'h55); send_flag();
      drain("R9 abort");

      // R10: three extra bits before the closing flag
      send_flag(); tx_crc = 16'hFFFF;
      send_dbyte(8'hA1); send_dbyte(8'hB2);
      begin
         logic [15:0] f = ~tx_crc;
         send_dbyte(f[7:0]); send_dbyte(f[15:8]);
      end
      send_dbit(0); send_dbit(1); send_dbit(0);
      send_flag();
      push_exp(8'hA1); push_exp(8'hB2);
      push_status(8'h04 | ((tx_crc != 16'hF0B8) ? 8'h01 : 8'h00));
      drain("R10 non-integral");

      // R11: loss of alignment mid-frame, then a normal frame
      send_flag(); send_dbyte(8'h11); send_dbyte(8'h22); send_dbyte(8'h33);
      lof = 1'b1; @(negedge clk); lof = 1'b0;
      push_status(8'h02);
      drain("R11 alignment loss");
      fr[0] = 8'h42;
      send_frame(1, 1'b0, 1'b0, 1'b1);
      drain("R11 recovery frame");

      // R3: disabled receiver stores nothing
      rx_en = 1'b0;
      fr[0] = 8'h99; fr[1] = 8'h66;
      send_frame(2, 1'b0, 1'b0, 1'b0);
      chk(fifo_count == 0, "R3 disabled", fifo_count, 0);
      rx_en = 1'b1;

      // R13: read of an empty FIFO has no effect
      rd_en = 1'b1; @(negedge clk); rd_en = 1'b0;
      fr[0] = 8'h0F;
      send_frame(1, 1'b0, 1'b0, 1'b1);
      drain("R13 read while empty");

      // R12: five report frames overflow the 64 entries
      prm_mode = 1'b1;
      for (int k = 0; k < 5; k++) begin
         for (int i = 0; i < 11; i++) fr[i] = 8'(k * 16 + i);
         send_frame(11, 1'b0, 1'b1, 1'b1);
      end
      chk(fifo_full && fifo_count == 64, "R12 full", fifo_count, 64);
      drain("R12 overflow contents");
      prm_mode = 1'b0;
      fr[0] = 8'hA5;
      send_frame(1, 1'b0, 1'b0, 1'b1);
      chk(q.size() == 2 && q[1] == 8'h08, "R12 sticky model", q[1], 8'h08);
      drain("R12 sticky overflow status");
      fr[0] = 8'h5A;
      send_frame(1, 1'b0, 1'b0, 1'b1);
      drain("R12 overflow cleared");

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule